// File: doc/BRIEF.md
# Handshake-Paced Byte Transfer Engine

This block is the device end of a byte-serial link to a host processor. The host paces the link with two handshake lines in the port-B byte: transfer-in-progress on bit 5 and acknowledge on bit 4. The device answers on a request line that sits at bit 3 of the same port. All three lines are active low. A shift-register byte carries the data. Bit 4 of the auxiliary control byte selects the direction. When it is 1, the host sends bytes, which are collected into a 16-entry outbound packet buffer. When it is 0, the device returns bytes from a 16-entry response buffer.

Each byte moves when a port-B write changes the transfer-in-progress/acknowledge pair while a transfer is active. When the transfer ends, a non-empty outbound packet is handed to a downstream command processor with a one-cycle strobe and a length. Between transfers, the request line follows the acknowledge line as a sync handshake. The block schedules a shift-register interrupt after every byte, at every sync toggle, at every transfer end and at every response load. The interrupt is delayed by a parameterised cycle count, except when the port-B direction byte is all ones, in which case it is raised at the next clock edge. A read of the shift register clears the flag.

Top module: `hs_xfer_engine`

## Requirements
- R1: After reset, `req_n` is 1 (request inactive), `sr_irq` is 0 and `pkt_valid` is 0.
- R2: Host-to-device mode is selected by `aux_ctrl[4]`=1, and a transfer is active while `pb_wdata[5]` is 0. In this mode, a port-B write whose pair {`pb_wdata[5]`,`pb_wdata[4]`} differs from the previously written pair appends `sr_data` to the outbound buffer and schedules the interrupt. A write that repeats the pair captures nothing and schedules nothing.
- R3: The outbound buffer holds DEPTH (16) bytes. Steps beyond that are dropped and schedule no interrupt.
- R4: A port-B write that raises `pb_wdata[5]` after it was 0 gives a one-cycle `pkt_valid` with `pkt_len` equal to the bytes captured, provided that count is non-zero. Entry 0 of `pkt_raddr` is the first byte, and the next packet starts again at entry 0.
- R5: In device-to-host mode (`aux_ctrl[4]`=0), each active step with a changed pair loads the next response byte into `sr_data`. The step that loads the last byte drives `req_n` to 1.
- R6: A `rsp_load` pulse restarts response reading at entry 0 with length `rsp_len` (clamped to DEPTH) and schedules the interrupt. If the last written `pb_wdata[5]` was 1 and the length is non-zero, it drives `req_n` to 0.
- R7: On a port-B write with `pb_wdata[5]`=1, where the previous write also had it at 1 and `pb_wdata[4]` changed, `req_n` takes the new `pb_wdata[4]` level and the interrupt is scheduled.
- R8: A scheduled interrupt sets `sr_irq` exactly DELAY_CYCLES clock edges after the scheduling edge. If `ddr_b` is 8'hFF, it sets `sr_irq` at the scheduling edge itself, so the flag is visible one cycle after the triggering strobe.
- R9: A `sr_rd` pulse clears `sr_irq`, unless the flag is being set on the same edge.
- R10: The end of a transfer always schedules the interrupt, even when no byte was captured. In that case there is no `pkt_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pb_wr | input | 1 | Port-B write strobe; evaluates the handshake |
| pb_wdata | input | 8 | Port-B write byte; bit 5 transfer-in-progress, bit 4 acknowledge (active low) |
| aux_ctrl | input | 8 | Auxiliary control byte; bit 4 = 1 host-to-device |
| ddr_b | input | 8 | Port-B direction byte; 8'hFF selects immediate interrupt |
| sr_wr | input | 1 | Host write of the shift register |
| sr_wdata | input | 8 | Shift-register write byte |
| sr_rd | input | 1 | Host read of the shift register; clears the flag |
| sr_data | output | 8 | Shift-register contents |
| sr_irq | output | 1 | Shift-register interrupt flag |
| req_n | output | 1 | Request line (port-B bit 3, active low) |
| rsp_wr | input | 1 | Response buffer write strobe |
| rsp_waddr | input | 4 | Response buffer write entry |
| rsp_wdata | input | 8 | Response buffer write byte |
| rsp_load | input | 1 | Start a new response; ignored in a cycle with `pb_wr` |
| rsp_len | input | 5 | Response length in bytes |
| pkt_valid | output | 1 | One-cycle outbound packet complete strobe |
| pkt_len | output | 5 | Outbound packet length |
| pkt_raddr | input | 4 | Outbound buffer read entry |
| pkt_rdata | output | 8 | Outbound buffer byte at `pkt_raddr` |

## Verification
The bench repeats a handshake pair during an active transfer. A design that stepped on every write instead of on a change would capture a duplicate byte and raise a spurious interrupt. It pushes a seventeenth byte into a full outbound buffer and expects a length of 16 with no interrupt. An overrunning index would corrupt the length or fire the flag. It follows a response through to its last byte and then loads a one-byte response, so a read index that was not restarted, or a request line released one byte early or late, shows up at `sr_data` and `req_n`. It also counts the delayed interrupt edge by edge, and ends a device-to-host transfer with nothing captured, which must give the interrupt but no packet strobe.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned PB_TIP_BIT  = 5;
  localparam int unsigned PB_ACK_BIT  = 4;
  localparam int unsigned AUX_DIR_BIT = 4;
  localparam logic [7:0]  DDR_ALL_OUT = 8'hFF;

  // Clamp a requested response length to the buffer depth.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned depth);
    return (req > depth) ? depth : req;
  endfunction

  // True when the byte at idx is the final one of a len-byte response.
  function automatic logic is_final(int unsigned idx, int unsigned len);
    return (idx + 1) >= len;
  endfunction
endpackage

// File: rtl/hs_byte_buf.sv
module hs_byte_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/hs_step.sv
module hs_step #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input  logic            tip,
  input  logic            tack,
  input  logic            last_tip,
  input  logic            last_tack,
  input  logic            dir_in,
  input  logic            treq_q,
  input  logic [IDXW-1:0] out_idx,
  input  logic [IDXW-1:0] in_idx,
  input  logic [IDXW-1:0] in_len,
  output logic            cap_en,
  output logic            give_en,
  output logic            pkt_done,
  output logic            sched,
  output logic            treq_nxt
);
  import hs_pkg::*;
  localparam logic [IDXW-1:0] FULL = IDXW'(DEPTH);

  logic pair_chg;
  assign pair_chg = (tip != last_tip) || (tack != last_tack);

  always_comb begin
    cap_en   = 1'b0;
    give_en  = 1'b0;
    pkt_done = 1'b0;
    sched    = 1'b0;
    treq_nxt = treq_q;
    if (!tip) begin
      if (dir_in) begin
        if (pair_chg && (out_idx < FULL)) begin
          cap_en = 1'b1;
          sched  = 1'b1;
        end
      end else if (pair_chg && (in_idx < in_len)) begin
        give_en = 1'b1;
        sched   = 1'b1;
        if (is_final(32'(in_idx), 32'(in_len))) treq_nxt = 1'b1;
      end
    end else if (last_tip && (tack != last_tack)) begin
      treq_nxt = tack;
      sched    = 1'b1;
    end else begin
      if (!last_tip) begin
        pkt_done = (out_idx != '0);
        sched    = 1'b1;
      end
      if (in_idx < in_len) treq_nxt = 1'b0;
    end
  end
endmodule

// File: rtl/hs_irq_delay.sv
module hs_irq_delay #(
  parameter int DELAY_CYCLES = 60000,
  localparam int CW = $clog2(DELAY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sched,
  input  logic immediate,
  input  logic clr,
  output logic set_pulse,
  output logic flag
);
  logic [CW-1:0] cnt;
  logic          arm;
  logic          fire;

  assign arm       = sched && !immediate;
  assign fire      = (cnt == CW'(1)) && !arm;
  assign set_pulse = (sched && immediate) || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (arm)              cnt <= CW'(DELAY_CYCLES);
      else if (cnt != '0)   cnt <= cnt - CW'(1);
      if (set_pulse)        flag <= 1'b1;
      else if (clr)         flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hs_xfer_engine.sv
module hs_xfer_engine #(
  parameter int DEPTH        = 16,
  parameter int DELAY_CYCLES = 60000,
  localparam int AW   = $clog2(DEPTH),
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pb_wr,
  input  logic [7:0]      pb_wdata,
  input  logic [7:0]      aux_ctrl,
  input  logic [7:0]      ddr_b,
  input  logic            sr_wr,
  input  logic [7:0]      sr_wdata,
  input  logic            sr_rd,
  output logic [7:0]      sr_data,
  output logic            sr_irq,
  output logic            req_n,
  input  logic            rsp_wr,
  input  logic [AW-1:0]   rsp_waddr,
  input  logic [7:0]      rsp_wdata,
  input  logic            rsp_load,
  input  logic [IDXW-1:0] rsp_len,
  output logic            pkt_valid,
  output logic [IDXW-1:0] pkt_len,
  input  logic [AW-1:0]   pkt_raddr,
  output logic [7:0]      pkt_rdata
);
  import hs_pkg::*;

  logic            last_tip, last_tack, treq_q;
  logic [7:0]      sr_q;
  logic [IDXW-1:0] out_idx, in_idx, in_len;
  logic            pkt_valid_q;
  logic [IDXW-1:0] pkt_len_q;

  logic tip, tack, dir_in;
  assign tip    = pb_wdata[PB_TIP_BIT];
  assign tack   = pb_wdata[PB_ACK_BIT];
  assign dir_in = aux_ctrl[AUX_DIR_BIT];

  logic unused_bits;
  assign unused_bits = ^{pb_wdata[7:6], pb_wdata[3:0], aux_ctrl[7:5], aux_ctrl[3:0]};

  logic cap_en, give_en, pkt_done, step_sched, treq_nxt;
  hs_step #(.DEPTH(DEPTH)) u_step (
    .tip(tip), .tack(tack), .last_tip(last_tip), .last_tack(last_tack),
    .dir_in(dir_in), .treq_q(treq_q),
    .out_idx(out_idx), .in_idx(in_idx), .in_len(in_len),
    .cap_en(cap_en), .give_en(give_en), .pkt_done(pkt_done),
    .sched(step_sched), .treq_nxt(treq_nxt)
  );

  // Named events for the checker.
  logic ev_cap, ev_give, ev_pkt, ev_load, ev_sched;
  assign ev_cap   = pb_wr && cap_en;
  assign ev_give  = pb_wr && give_en;
  assign ev_pkt   = pb_wr && pkt_done;
  assign ev_load  = !pb_wr && rsp_load;
  assign ev_sched = (pb_wr && step_sched) || ev_load;

  logic [IDXW-1:0] load_len;
  assign load_len = IDXW'(clamp_len(32'(rsp_len), DEPTH));

  logic [7:0] rsp_rdata;
  hs_byte_buf #(.DEPTH(DEPTH)) u_rsp_buf (
    .clk(clk), .wr_en(rsp_wr), .wr_addr(rsp_waddr), .wr_data(rsp_wdata),
    .rd_addr(in_idx[AW-1:0]), .rd_data(rsp_rdata)
  );

  hs_byte_buf #(.DEPTH(DEPTH)) u_out_buf (
    .clk(clk), .wr_en(ev_cap), .wr_addr(out_idx[AW-1:0]), .wr_data(sr_q),
    .rd_addr(pkt_raddr), .rd_data(pkt_rdata)
  );

  logic irq_set;
  hs_irq_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_irq (
    .clk(clk), .rst_n(rst_n), .sched(ev_sched),
    .immediate(ddr_b == DDR_ALL_OUT), .clr(sr_rd),
    .set_pulse(irq_set), .flag(sr_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tip    <= 1'b1;
      last_tack   <= 1'b1;
      treq_q      <= 1'b1;
      sr_q        <= '0;
      out_idx     <= '0;
      in_idx      <= '0;
      in_len      <= '0;
      pkt_valid_q <= 1'b0;
      pkt_len_q   <= '0;
    end else begin
      pkt_valid_q <= ev_pkt;
      if (ev_pkt) pkt_len_q <= out_idx;
      if (ev_give)    sr_q <= rsp_rdata;
      else if (sr_wr) sr_q <= sr_wdata;
      if (pb_wr) begin
        last_tip  <= tip;
        last_tack <= tack;
        treq_q    <= treq_nxt;
        if (ev_cap)       out_idx <= out_idx + IDXW'(1);
        else if (ev_pkt)  out_idx <= '0;
        if (ev_give)      in_idx  <= in_idx + IDXW'(1);
      end else if (rsp_load) begin
        in_idx <= '0;
        in_len <= load_len;
        if (last_tip && (load_len != '0)) treq_q <= 1'b0;
      end
    end
  end

  assign sr_data   = sr_q;
  assign req_n     = treq_q;
  assign pkt_valid = pkt_valid_q;
  assign pkt_len   = pkt_len_q;
endmodule

// File: rtl/hs_xfer_engine_chk.sv
module hs_xfer_engine_chk #(
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pb_wr,
  input logic [7:0]      pb_wdata,
  input logic [7:0]      ddr_b,
  input logic            sr_rd,
  input logic            sr_irq,
  input logic            req_n,
  input logic            pkt_valid,
  input logic [IDXW-1:0] pkt_len,
  input logic            last_tip,
  input logic            last_tack,
  input logic [IDXW-1:0] out_idx,
  input logic [IDXW-1:0] in_idx,
  input logic [IDXW-1:0] in_len,
  input logic            ev_cap,
  input logic            ev_give,
  input logic            ev_sched,
  input logic            irq_set
);
  localparam logic [IDXW-1:0] FULL = IDXW'(DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_idx <= FULL); // R3
  AST_CAP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap |-> out_idx < FULL); // R3
  AST_PKT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid); // R4
  AST_PKT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_len != '0); // R4
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_give && (in_idx + IDXW'(1) == in_len)) |=> req_n); // R5
  AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wr && pb_wdata[5] && last_tip && (pb_wdata[4] != last_tack))
      |=> (req_n == $past(pb_wdata[4]))); // R7
  AST_IMMEDIATE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sched && ddr_b == 8'hFF) |=> sr_irq); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd && !irq_set) |=> !sr_irq); // R9
  AST_END_SCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_wr && pb_wdata[5] && !last_tip) |-> ev_sched); // R10
endmodule

bind hs_xfer_engine hs_xfer_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
  .ddr_b(ddr_b), .sr_rd(sr_rd), .sr_irq(sr_irq), .req_n(req_n),
  .pkt_valid(pkt_valid), .pkt_len(pkt_len),
  .last_tip(last_tip), .last_tack(last_tack),
  .out_idx(out_idx), .in_idx(in_idx), .in_len(in_len),
  .ev_cap(ev_cap), .ev_give(ev_give), .ev_sched(ev_sched),
  .irq_set(irq_set)
);

// File: tb/hs_xfer_engine_bench.sv
`timescale 1ns/1ps
module hs_xfer_engine_bench;
  localparam int DEPTH = 16;
  localparam int DELAY = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pb_wr = 1'b0;
  logic [7:0] pb_wdata = 8'h30;
  logic [7:0] aux_ctrl = 8'h00;
  logic [7:0] ddr_b = 8'hFF;
  logic       sr_wr = 1'b0;
  logic [7:0] sr_wdata = 8'h00;
  logic       sr_rd = 1'b0;
  logic [7:0] sr_data;
  logic       sr_irq, req_n;
  logic       rsp_wr = 1'b0;
  logic [3:0] rsp_waddr = '0;
  logic [7:0] rsp_wdata = '0;
  logic       rsp_load = 1'b0;
  logic [4:0] rsp_len = '0;
  logic       pkt_valid;
  logic [4:0] pkt_len;
  logic [3:0] pkt_raddr = '0;
  logic [7:0] pkt_rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hs_xfer_engine #(.DEPTH(DEPTH), .DELAY_CYCLES(DELAY)) u_hs_xfer_engine (
    .clk(clk), .rst_n(rst_n), .pb_wr(pb_wr), .pb_wdata(pb_wdata),
    .aux_ctrl(aux_ctrl), .ddr_b(ddr_b), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .sr_rd(sr_rd), .sr_data(sr_data), .sr_irq(sr_irq), .req_n(req_n),
    .rsp_wr(rsp_wr), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
    .rsp_load(rsp_load), .rsp_len(rsp_len), .pkt_valid(pkt_valid),
    .pkt_len(pkt_len), .pkt_raddr(pkt_raddr), .pkt_rdata(pkt_rdata)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pb(bit tip, bit tack);
    @(negedge clk); pb_wr = 1'b1; pb_wdata = {2'b00, tip, tack, 4'b0000};
    @(negedge clk); pb_wr = 1'b0;
  endtask

  task automatic sr_put(logic [7:0] v);
    @(negedge clk); sr_wr = 1'b1; sr_wdata = v;
    @(negedge clk); sr_wr = 1'b0;
  endtask

  task automatic sr_get();
    @(negedge clk); sr_rd = 1'b1;
    @(negedge clk); sr_rd = 1'b0;
  endtask

  task automatic rsp_put(int a, logic [7:0] v);
    @(negedge clk); rsp_wr = 1'b1; rsp_waddr = 4'(a); rsp_wdata = v;
    @(negedge clk); rsp_wr = 1'b0;
  endtask

  task automatic rsp_go(int n);
    @(negedge clk); rsp_load = 1'b1; rsp_len = 5'(n);
    @(negedge clk); rsp_load = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 req_n", int'(req_n), 1);
    chk("R1 sr_irq", int'(sr_irq), 0);
    chk("R1 pkt_valid", int'(pkt_valid), 0);
  endtask

  task automatic t_host_send();
    ddr_b = 8'hFF; aux_ctrl = 8'h10;
    sr_put(8'hA5);
    pb(0, 1);
    chk("R2/R8 irq after capture", int'(sr_irq), 1);
    sr_get();
    chk("R9 read clears irq", int'(sr_irq), 0);
    sr_put(8'h3C);
    pb(0, 1);
    chk("R2 repeated pair no irq", int'(sr_irq), 0);
    pb(0, 0);
    chk("R2 second capture irq", int'(sr_irq), 1);
    sr_get();
    pb(1, 0);
    chk("R4 pkt_valid", int'(pkt_valid), 1);
    chk("R4 pkt_len two", int'(pkt_len), 2);
    chk("R10 end irq", int'(sr_irq), 1);
    chk("R4 req_n idle", int'(req_n), 1);
    pkt_raddr = 4'd0; #1;
    chk("R4 byte0", int'(pkt_rdata), 'hA5);
    pkt_raddr = 4'd1; #1;
    chk("R2 byte1 not duplicated", int'(pkt_rdata), 'h3C);
    @(negedge clk);
    chk("R4 strobe one cycle", int'(pkt_valid), 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i <= DEPTH; i++) begin
      sr_put(8'(i + 1));
      if (i == DEPTH) sr_get();
      pb(0, (i % 2) == 0);
    end
    chk("R3 no irq on dropped byte", int'(sr_irq), 0);
    pb(1, 1);
    chk("R3 pkt_len capped", int'(pkt_len), DEPTH);
    pkt_raddr = 4'd0; #1;
    chk("R4 restart at entry0", int'(pkt_rdata), 1);
    pkt_raddr = 4'd15; #1;
    chk("R3 last kept byte", int'(pkt_rdata), DEPTH);
  endtask

  task automatic t_device_send();
    aux_ctrl = 8'h00;
    sr_get();
    rsp_put(0, 8'h11); rsp_put(1, 8'h22); rsp_put(2, 8'h33);
    rsp_go(3);
    chk("R6 req_n low on load", int'(req_n), 0);
    chk("R6 irq on load", int'(sr_irq), 1);
    sr_get();
    pb(0, 0);
    chk("R5 byte0", int'(sr_data), 'h11);
    chk("R5 req held", int'(req_n), 0);
    pb(0, 1);
    chk("R5 byte1", int'(sr_data), 'h22);
    pb(0, 0);
    chk("R5 byte2", int'(sr_data), 'h33);
    chk("R5 release on last", int'(req_n), 1);
    sr_get();
    pb(1, 0);
    chk("R10 no pkt when empty", int'(pkt_valid), 0);
    chk("R10 irq at end", int'(sr_irq), 1);
    rsp_put(0, 8'h44);
    rsp_go(1);
    chk("R6 req_n low again", int'(req_n), 0);
    pb(0, 1);
    chk("R6 index restarted", int'(sr_data), 'h44);
    chk("R5 single byte release", int'(req_n), 1);
    pb(1, 1);
  endtask

  task automatic t_sync();
    pb(1, 0);
    chk("R7 req follows tack low", int'(req_n), 0);
    pb(1, 1);
    chk("R7 req follows tack high", int'(req_n), 1);
    pb(1, 0);
    chk("R7 req follows tack low2", int'(req_n), 0);
  endtask

  task automatic t_delay();
    ddr_b = 8'h00;
    sr_get();
    pb(1, 1);
    repeat (DELAY - 1) @(negedge clk);
    chk("R8 not early", int'(sr_irq), 0);
    @(negedge clk);
    chk("R8 at delay", int'(sr_irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_host_send();
    t_overflow();
    t_device_send();
    t_sync();
    t_delay();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule